// File: doc/BRIEF.md
# Character LCD start-up and write sequencer

This block brings an 8-bit parallel character LCD controller out of power-up and then serves as its write port. After reset it lets the power-on settle time run out. It then sends four configuration instructions, each one followed by the idle time the controller needs before it can take another byte: bus and font configuration, display enable, screen clear and address-step mode. Once this sequence has finished, the block raises `ready`. A host writes one character by pulsing `wr_valid` with the byte on `wr_char` while `ready` is high.

The block never reads from the controller. The read/write line is held at write, and every wait is a counted interval. Each byte goes out with register-select and the data bus set up first. The enable line is then raised for a minimum high time and dropped, and the controller latches the byte on that falling edge. Every interval is converted from nanoseconds to clock cycles using a clock-frequency parameter, always rounding up.

Top module: `lcd_init_seq`

## Requirements
- R1: While reset is held and in the cycle after it is released, `ready` is 0, `lcd_e` is 0 and `lcd_rw` is 0.
- R2: The first rising edge of `lcd_e` comes no earlier than the power-on wait (default 20 ms) after reset is released.
- R3: The first four bytes latched (at the falling edge of `lcd_e`) are 0x38, 0x0C, 0x01 and 0x06, in that order, each with `lcd_rs` = 0. The bit fields of these codes are: 0x38 = 8-bit bus, two lines, 5x8 font. 0x0C = display on, cursor off, no blink. 0x01 = clear. 0x06 = increment, no shift.
- R4: After the first, second and fourth instruction, `lcd_e` stays low for at least the short command wait (default 37 us) before it rises again or `ready` rises.
- R5: After the clear instruction, `lcd_e` stays low for at least the clear wait (default 1.52 ms) before the next rise.
- R6: `lcd_rs` and `lcd_db` hold their values for at least one cycle before `lcd_e` rises and throughout the high phase. `lcd_e` stays high for at least the minimum pulse width (default 1 us).
- R7: `ready` first rises only after the fourth instruction has been latched. No transfer happens before that except the four instructions.
- R8: A write accepted with `ready` high puts `wr_char` on the bus with `lcd_rs` = 1. `ready` falls in the next cycle and rises again no sooner than the data wait (default 37 us) after `lcd_e` falls.
- R9: A `wr_valid` pulse while `ready` is low produces no transfer and is not queued.
- R10: `lcd_rw` is 0 at all times.
- R11: Each wait is ceil(CLK_HZ × ns / 10^9) cycles, with a minimum of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host write strobe, sampled only while `ready` is high |
| wr_char | input | 8 | Character byte to write |
| ready | output | 1 | High when a host write can be accepted |
| lcd_rs | output | 1 | Register select: 0 for an instruction, 1 for data |
| lcd_rw | output | 1 | Read/write select, always 0 (write) |
| lcd_e | output | 1 | Enable strobe; the byte is latched on its falling edge |
| lcd_db | output | 8 | Parallel data bus |

## Verification
The bench uses a 2.5 MHz clock setting, where 37 us and 1 us do not divide into whole cycles. A design that rounds down would therefore shorten those gaps by one cycle, and the bench's lower-bound checks would report it. The bench sends all 256 character values, follows each accepted write with a stray strobe, and also sends strobes during the power wait and during the clear wait. Any design that queued or accepted those strobes would add transfers, which shows up as a byte mismatch or a wrong transfer count. Every enable pulse is also checked for setup and hold stability, so a design that loaded the bus in the same cycle that it raised enable would be caught.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [1:0] {
    SQ_POWER,
    SQ_XFER,
    SQ_GAP,
    SQ_READY
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE
  } strobe_phase_t;

  // Round-up conversion of a duration in ns to clock cycles, floor of one.
  function automatic int unsigned ns_to_cycles(longint unsigned clk_hz,
                                               longint unsigned ns);
    longint unsigned prod;
    longint unsigned cyc;
    prod = clk_hz * ns;
    cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    if (cyc == 0) cyc = 1;
    return int'(cyc);
  endfunction

  function automatic int unsigned max_of(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Interface configuration: 8-bit bus fixed, line count and font selectable.
  function automatic logic [7:0] code_config(bit two_lines, bit tall_font);
    return 8'h30 | (8'(two_lines) << 3) | (8'(tall_font) << 2);
  endfunction

  function automatic logic [7:0] code_display(bit disp_on, bit cursor_on,
                                              bit blink_on);
    return 8'h08 | (8'(disp_on) << 2) | (8'(cursor_on) << 1) | 8'(blink_on);
  endfunction

  localparam logic [7:0] CODE_CLEAR = 8'h01;

  function automatic logic [7:0] code_entry(bit addr_inc, bit shift_on);
    return 8'h04 | (8'(addr_inc) << 1) | 8'(shift_on);
  endfunction

endpackage

// File: rtl/lcd_wait_timer.sv
module lcd_wait_timer #(
  parameter int unsigned W         = 16,
  parameter int unsigned RESET_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         idle
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= W'(RESET_VAL);
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  assign idle = (cnt == '0) && !load;

endmodule

// File: rtl/lcd_bus_strobe.sv
module lcd_bus_strobe
  import lcd_seq_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned EHI_CYC   = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_rs,
  input  logic [7:0] start_byte,
  output logic       lcd_rs,
  output logic       lcd_e,
  output logic [7:0] lcd_db,
  output logic       done
);

  localparam int unsigned SETUP_EFF = max_of(SETUP_CYC, 1);
  localparam int unsigned EHI_EFF   = max_of(EHI_CYC, 1);
  localparam int unsigned CW        = $clog2(max_of(SETUP_EFF, EHI_EFF) + 1);

  strobe_phase_t ph;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      lcd_e  <= 1'b0;
      lcd_rs <= 1'b0;
      lcd_db <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (start) begin
            lcd_rs <= start_rs;
            lcd_db <= start_byte;
            cnt    <= CW'(SETUP_EFF - 1);
            ph     <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            lcd_e <= 1'b1;
            cnt   <= CW'(EHI_EFF - 1);
            ph    <= PH_PULSE;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        PH_PULSE: begin
          if (cnt == '0) begin
            lcd_e <= 1'b0;
            done  <= 1'b1;
            ph    <= PH_IDLE;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 200_000_000,
  parameter int unsigned PWR_NS    = 20_000_000,
  parameter int unsigned CMD_NS    = 37_000,
  parameter int unsigned CLR_NS    = 1_520_000,
  parameter int unsigned DATA_NS   = 37_000,
  parameter int unsigned SETUP_NS  = 40,
  parameter int unsigned EHI_NS    = 1_000,
  parameter bit          TWO_LINES = 1'b1,
  parameter bit          TALL_FONT = 1'b0,
  parameter bit          CURSOR_ON = 1'b0,
  parameter bit          BLINK_ON  = 1'b0,
  parameter bit          ADDR_INC  = 1'b1,
  parameter bit          SHIFT_ON  = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic [7:0] wr_char,
  output logic       ready,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [7:0] lcd_db
);

  localparam int unsigned PWR_CYC   = ns_to_cycles(CLK_HZ, PWR_NS);
  localparam int unsigned CMD_CYC   = ns_to_cycles(CLK_HZ, CMD_NS);
  localparam int unsigned CLR_CYC   = ns_to_cycles(CLK_HZ, CLR_NS);
  localparam int unsigned DATA_CYC  = ns_to_cycles(CLK_HZ, DATA_NS);
  localparam int unsigned SETUP_CYC = ns_to_cycles(CLK_HZ, SETUP_NS);
  localparam int unsigned EHI_CYC   = ns_to_cycles(CLK_HZ, EHI_NS);
  localparam int unsigned MAX_WAIT  =
    max_of(max_of(PWR_CYC, CLR_CYC), max_of(CMD_CYC, DATA_CYC));
  localparam int unsigned TW        = $clog2(MAX_WAIT + 1);

  localparam logic [7:0] OP_CONFIG  = code_config(TWO_LINES, TALL_FONT);
  localparam logic [7:0] OP_DISPLAY = code_display(1'b1, CURSOR_ON, BLINK_ON);
  localparam logic [7:0] OP_ENTRY   = code_entry(ADDR_INC, SHIFT_ON);

  localparam logic [2:0] STEP_DATA = 3'd4;

  seq_state_t     st;
  logic [2:0]     step;
  logic           init_done;
  logic           tmr_idle;
  logic           tmr_load;
  logic [TW-1:0]  tmr_val;
  logic           xfer_start;
  logic           xfer_rs;
  logic [7:0]     xfer_byte;
  logic           xfer_done;

  function automatic logic [7:0] op_for_step(logic [2:0] s);
    case (s)
      3'd0:    return OP_CONFIG;
      3'd1:    return OP_DISPLAY;
      3'd2:    return CODE_CLEAR;
      default: return OP_ENTRY;
    endcase
  endfunction

  // Wait that must follow the transfer issued at step s.
  function automatic logic [TW-1:0] gap_after(logic [2:0] s);
    case (s)
      3'd2:      return TW'(CLR_CYC);
      STEP_DATA: return TW'(DATA_CYC);
      default:   return TW'(CMD_CYC);
    endcase
  endfunction

  assign init_done = (step == STEP_DATA);
  assign ready     = (st == SQ_READY);
  assign lcd_rw    = 1'b0;

  always_comb begin
    xfer_start = 1'b0;
    xfer_rs    = init_done;
    xfer_byte  = init_done ? wr_char : op_for_step(step);
    case (st)
      SQ_POWER, SQ_GAP: xfer_start = tmr_idle && !init_done;
      SQ_READY:         xfer_start = wr_valid;
      default:          xfer_start = 1'b0;
    endcase
    tmr_load = (st == SQ_XFER) && xfer_done;
    tmr_val  = gap_after(step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SQ_POWER;
      step <= '0;
    end else begin
      case (st)
        SQ_POWER: if (xfer_start) st <= SQ_XFER;
        SQ_XFER: begin
          if (xfer_done) begin
            st <= SQ_GAP;
            if (!init_done) step <= step + 3'd1;
          end
        end
        SQ_GAP: if (tmr_idle) st <= init_done ? SQ_READY : SQ_XFER;
        SQ_READY: if (wr_valid) st <= SQ_XFER;
        default: st <= SQ_POWER;
      endcase
    end
  end

  lcd_wait_timer #(
    .W         (TW),
    .RESET_VAL (PWR_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .idle     (tmr_idle)
  );

  lcd_bus_strobe #(
    .SETUP_CYC (SETUP_CYC),
    .EHI_CYC   (EHI_CYC)
  ) u_strobe (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (xfer_start),
    .start_rs   (xfer_rs),
    .start_byte (xfer_byte),
    .lcd_rs     (lcd_rs),
    .lcd_e      (lcd_e),
    .lcd_db     (lcd_db),
    .done       (xfer_done)
  );

endmodule

// File: rtl/lcd_init_seq_chk.sv
module lcd_init_seq_chk #(
  parameter int unsigned PWR_CYC = 1,
  parameter int unsigned MIN_GAP = 1,
  parameter int unsigned EHI_CYC = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       ready,
  input logic       lcd_rs,
  input logic       lcd_rw,
  input logic       lcd_e,
  input logic [7:0] lcd_db,
  input logic       xfer_start,
  input logic       init_done
);

  logic        prev_e;
  logic        seen_fall;
  int unsigned since_fall;
  int unsigned high_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_e     <= 1'b0;
      seen_fall  <= 1'b0;
      since_fall <= 0;
      high_len   <= 0;
    end else begin
      prev_e <= lcd_e;
      if (prev_e && !lcd_e) begin
        seen_fall  <= 1'b1;
        since_fall <= 0;
      end else if (since_fall != 32'hFFFF_FFFF) begin
        since_fall <= since_fall + 1;
      end
      high_len <= lcd_e ? high_len + 1 : 0;
    end
  end

  AST_RW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_rw == 1'b0);  // R10

  AST_SETUP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_e) |-> $stable(lcd_db) && $stable(lcd_rs));  // R6

  AST_HIGH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_e && prev_e |-> $stable(lcd_db) && $stable(lcd_rs));  // R6

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    prev_e && !lcd_e |-> high_len >= EHI_CYC);  // R6

  AST_PWR_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_e && !prev_e && !seen_fall |-> since_fall >= PWR_CYC);  // R2

  AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_e && !prev_e && seen_fall |-> since_fall >= MIN_GAP);  // R4

  AST_NO_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start && init_done |-> ready);  // R9

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ready && wr_valid |=> !ready);  // R8

  AST_INIT_RS: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_e |-> lcd_rs == init_done);  // R3

  AST_READY_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> init_done && !lcd_e);  // R7

endmodule

bind lcd_init_seq lcd_init_seq_chk #(
  .PWR_CYC (PWR_CYC),
  .MIN_GAP (CMD_CYC),
  .EHI_CYC (EHI_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .ready      (ready),
  .lcd_rs     (lcd_rs),
  .lcd_rw     (lcd_rw),
  .lcd_e      (lcd_e),
  .lcd_db     (lcd_db),
  .xfer_start (xfer_start),
  .init_done  (init_done)
);

// File: tb/lcd_init_seq_test.sv
module lcd_init_seq_test;

  localparam int unsigned HZ = 2_500_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_char = 8'h00;
  logic       ready, lcd_rs, lcd_rw, lcd_e;
  logic [7:0] lcd_db;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lcd_init_seq #(.CLK_HZ(HZ)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_char(wr_char),
    .ready(ready), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e),
    .lcd_db(lcd_db)
  );

  // Cycle count from a duration, restated as quotient plus remainder test.
  function automatic longint cyc_for(longint ns);
    longint num, q;
    num = longint'(HZ) * ns;
    q   = num / 1_000_000_000;
    if (q * 1_000_000_000 < num) q = q + 1;
    if (q < 1) q = 1;
    return q;
  endfunction

  longint T_PWR, T_CMD, T_CLR, T_DATA, T_EHI;

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int idx);
    case (idx)
      0: return 8'h38;
      1: return 8'h0C;
      2: return 8'h01;
      3: return 8'h06;
      default: return 8'(idx - 4);
    endcase
  endfunction

  function automatic longint need_gap(int prev_idx);
    if (prev_idx == 2) return T_CLR;
    if (prev_idx >= 4) return T_DATA;
    return T_CMD;
  endfunction

  // Port monitor, sampled on the falling clock edge.
  longint     cyc = 0;
  longint     rise_at = 0, fall_at = 0;
  int         nxfer = 0;
  logic       p_e = 1'b0, p_rs = 1'b0, p_ready = 1'b0;
  logic [7:0] p_db = 8'h00;
  logic       h_rs;
  logic [7:0] h_db;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      check(lcd_rw == 1'b0, "R10 rw", lcd_rw, 0);
      if (lcd_e && !p_e) begin
        rise_at = cyc;
        check(lcd_rs == p_rs && lcd_db == p_db, "R6 setup", lcd_db, p_db);
        h_rs = lcd_rs; h_db = lcd_db;
        if (nxfer == 0)
          check(cyc >= T_PWR, "R2 power wait", cyc, T_PWR);
        else if (nxfer == 3)
          check(cyc - fall_at >= T_CLR && cyc - fall_at <= T_CLR + 8,
                "R5 clear gap", cyc - fall_at, T_CLR);
        else
          check(cyc - fall_at >= need_gap(nxfer - 1)
                && cyc - fall_at <= need_gap(nxfer - 1) + 8,
                "R4 gap", cyc - fall_at, need_gap(nxfer - 1));
      end
      if (lcd_e && p_e)
        check(lcd_rs == h_rs && lcd_db == h_db, "R6 hold", lcd_db, h_db);
      if (!lcd_e && p_e) begin
        fall_at = cyc;
        check(cyc - rise_at >= T_EHI, "R6 pulse width", cyc - rise_at, T_EHI);
        if (nxfer < 4) begin
          check(p_db == exp_byte(nxfer), "R3 init byte", p_db, exp_byte(nxfer));
          check(p_rs == 1'b0, "R3 rs low", p_rs, 0);
        end else begin
          check(p_db == exp_byte(nxfer), "R8 data byte", p_db, exp_byte(nxfer));
          check(p_rs == 1'b1, "R8 rs high", p_rs, 1);
        end
        nxfer++;
      end
      if (ready && !p_ready) begin
        if (nxfer == 4) begin
          check(1'b1, "R7 ready after init", nxfer, 4);
          check(cyc - fall_at >= T_CMD, "R4 entry gap", cyc - fall_at, T_CMD);
        end else if (nxfer < 4) begin
          check(1'b0, "R7 ready before init", nxfer, 4);
        end else begin
          check(cyc - fall_at >= T_DATA && cyc - fall_at <= T_DATA + 8,
                "R8 data wait", cyc - fall_at, T_DATA);
        end
      end
    end
    p_e = lcd_e; p_rs = lcd_rs; p_db = lcd_db; p_ready = ready;
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    T_PWR  = cyc_for(20_000_000);
    T_CMD  = cyc_for(37_000);
    T_CLR  = cyc_for(1_520_000);
    T_DATA = cyc_for(37_000);
    T_EHI  = cyc_for(1_000);
    // R11: rounding up at 2.5 MHz
    check(T_CMD == 93, "R11 cmd cycles", T_CMD, 93);
    check(T_EHI == 3, "R11 pulse cycles", T_EHI, 3);
    check(T_CLR == 3800, "R11 clear cycles", T_CLR, 3800);

    repeat (3) @(negedge clk);
    check(ready == 1'b0 && lcd_e == 1'b0 && lcd_rw == 1'b0, "R1 in reset",
          {ready, lcd_e, lcd_rw}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready == 1'b0 && lcd_e == 1'b0, "R1 after release", {ready, lcd_e}, 0);

    // R9: strobes during the power wait are dropped
    repeat (100) @(negedge clk);
    wr_valid = 1'b1; wr_char = 8'hAA;
    repeat (50) @(negedge clk);
    wr_valid = 1'b0;
    // R9: strobe during the clear wait
    while (nxfer < 3) @(negedge clk);
    repeat (10) @(negedge clk);
    wr_valid = 1'b1; wr_char = 8'h55;
    @(negedge clk);
    wr_valid = 1'b0;
    check(nxfer == 3, "R9 no transfer while busy", nxfer, 3);

    for (int v = 0; v < 256; v++) begin
      while (!ready) @(negedge clk);
      wr_valid = 1'b1; wr_char = 8'(v);
      @(negedge clk);
      check(ready == 1'b0, "R8 ready drop", ready, 0);
      wr_char = ~8'(v);  // stray strobe while busy, R9
      @(negedge clk);
      wr_valid = 1'b0;
    end
    while (!ready) @(negedge clk);
    repeat (20) @(negedge clk);
    check(nxfer == 260, "R9 transfer count", nxfer, 260);
    finish_run();
  end

endmodule